// File: doc/BRIEF.md
# Windowed Frame Memory Write Addresser

This block generates write addresses for a byte-wide frame memory that is organised as rows of packed pixel bytes. Each byte carries two 4-bit pixels, and the default geometry is 64 bytes across by 80 rows. The block keeps a current column pointer and a current row pointer. Both stay inside a rectangular window whose bounds the command parser programs.

Each incoming data byte is forwarded in the same clock cycle with a write enable and the address `row * COLS + col`. On the following clock edge the pointers advance.

- In horizontal order the column moves first. When it leaves the window it returns to the column start and the row steps.
- In vertical order the row moves first. When it leaves the window it returns to the row start and the column steps.

Either axis wraps back to its own start when it leaves the window. The storage sits outside the block, and so does the reading of the memory for display.

A sticky redraw flag records that the picture changed since the display side last cleared it.

Top module: `wa_frame_addr`

## Requirements
- R1: After reset `cur_col` and `cur_row` are 0, `redraw` is 0, and the window spans the whole frame. In that full window, COLS*ROWS writes in horizontal order visit the addresses 0 to COLS*ROWS-1 in sequence, and the next write goes to 0 again.
- R2: While `data_valid` is 1, `wr_en` is 1, `wr_data` equals `data_in` and `wr_addr` equals `cur_row*COLS + cur_col`, all in that same cycle. While `data_valid` is 0, `wr_en` is 0.
- R3: In horizontal order (`vertical` = 0), a write with the column below the column end increments the column and leaves the row unchanged. A write with the column at or beyond the end sets the column to the column start and advances the row.
- R4: In horizontal order, when the row advances from a value at or beyond the row end it becomes the row start instead, so the window returns to its origin.
- R5: In vertical order (`vertical` = 1), a write with the row below the row end increments the row and leaves the column unchanged. At or beyond the row end, the row becomes the row start and the column advances. A column at or beyond the column end becomes the column start.
- R6: A cycle with `col_load` = 1 stores `col_lo` and `col_hi` as the column window. From the next cycle `cur_col` equals `col_lo`.
- R7: A cycle with `row_load` = 1 stores `row_lo` mod ROWS and `row_hi` mod ROWS as the row window. From the next cycle `cur_row` equals `row_lo` mod ROWS, and `cur_row` is always below ROWS.
- R8: When a window end lies below its start, a pointer standing at the start returns to the start after a single step on that axis.
- R9: Any write sets `redraw` to 1 on the next cycle. A `redraw_clr` pulse without a write clears it. When a write and a clear happen in the same cycle, `redraw` ends up 1.
- R10: With `data_valid`, `col_load` and `row_load` all 0, the pointers keep their values and `wr_en` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_lo | input | CW | Column window start for a column load |
| col_hi | input | CW | Column window end for a column load |
| col_load | input | 1 | Load the column window and move the column pointer to its start |
| row_lo | input | RW | Row window start for a row load, taken mod ROWS |
| row_hi | input | RW | Row window end for a row load, taken mod ROWS |
| row_load | input | 1 | Load the row window and move the row pointer to its start |
| vertical | input | 1 | 1 selects row-first order, 0 selects column-first order |
| data_valid | input | 1 | A data byte is present this cycle |
| data_in | input | DW | Data byte (two 4-bit pixels) |
| redraw_clr | input | 1 | Display side clears the redraw flag |
| wr_en | output | 1 | Frame memory write enable |
| wr_addr | output | AW | Frame memory write address |
| wr_data | output | DW | Frame memory write data |
| cur_col | output | CW | Current column pointer |
| cur_row | output | RW | Current row pointer |
| redraw | output | 1 | Sticky flag: frame written since the last clear |

## Verification
The bench builds the block with COLS = 8 and ROWS = 10. The small column axis allows every one of the 64 start/end pairs to be swept in both orders. The 4-bit row inputs cover all 256 start/end codes, including the values 10 to 15 that must fold back mod 10. That brings every wrap combination within reach in a few tens of thousands of cycles:

- ends below starts
- single-entry windows
- a pointer already past its end

Because ROWS is not a power of two, the multiply in the address is also exercised.

// File: rtl/wa_frame_pkg.sv
package wa_frame_pkg;

    // Per-axis pointer action for one clock
    typedef enum logic [1:0] {
        AX_HOLD = 2'd0,
        AX_INC  = 2'd1,
        AX_WRAP = 2'd2
    } ax_step_e;

    typedef struct packed {
        ax_step_e col;
        ax_step_e row;
    } step_pair_t;

    // Decide both axis actions from the write strobe, the order and the end flags.
    // The primary axis always moves; the secondary one moves only when the
    // primary wraps, and then wraps itself when it sits at its own end.
    function automatic step_pair_t plan_steps(input logic valid,
                                              input logic vert,
                                              input logic col_end_hit,
                                              input logic row_end_hit);
        step_pair_t s;
        s.col = AX_HOLD;
        s.row = AX_HOLD;
        if (valid) begin
            if (vert) begin
                s.row = row_end_hit ? AX_WRAP : AX_INC;
                if (row_end_hit)
                    s.col = col_end_hit ? AX_WRAP : AX_INC;
            end else begin
                s.col = col_end_hit ? AX_WRAP : AX_INC;
                if (col_end_hit)
                    s.row = row_end_hit ? AX_WRAP : AX_INC;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/wa_axis.sv
module wa_axis
    import wa_frame_pkg::*;
#(
    parameter int SIZE = 64,
    localparam int W = $clog2(SIZE)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] ld_lo,
    input  logic [W-1:0] ld_hi,
    input  ax_step_e     step,
    output logic [W-1:0] cur,
    output logic         at_end
);
    logic [W-1:0] lo_q, hi_q;
    logic [W-1:0] lo_fold, hi_fold;

    // Fold out-of-range codes back into the axis (no-op for power-of-two sizes)
    assign lo_fold = W'(32'(ld_lo) % SIZE);
    assign hi_fold = W'(32'(ld_hi) % SIZE);

    // Passing the end means cur + 1 > hi, i.e. cur >= hi
    assign at_end = (cur >= hi_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= W'(SIZE - 1);
            cur  <= '0;
        end else if (load) begin
            lo_q <= lo_fold;
            hi_q <= hi_fold;
            cur  <= lo_fold;
        end else begin
            unique case (step)
                AX_INC:  cur <= cur + W'(1);
                AX_WRAP: cur <= lo_q;
                default: cur <= cur;
            endcase
        end
    end
endmodule

// File: rtl/wa_dirty.sv
module wa_dirty (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // A write in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/wa_frame_addr.sv
module wa_frame_addr
    import wa_frame_pkg::*;
#(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    parameter int DW   = 8,
    localparam int CW  = $clog2(COLS),
    localparam int RW  = $clog2(ROWS),
    localparam int AW  = $clog2(COLS * ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] col_lo,
    input  logic [CW-1:0] col_hi,
    input  logic          col_load,
    input  logic [RW-1:0] row_lo,
    input  logic [RW-1:0] row_hi,
    input  logic          row_load,
    input  logic          vertical,
    input  logic          data_valid,
    input  logic [DW-1:0] data_in,
    input  logic          redraw_clr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [CW-1:0] cur_col,
    output logic [RW-1:0] cur_row,
    output logic          redraw
);
    logic       col_at_end, row_at_end;
    step_pair_t steps;

    assign steps = plan_steps(data_valid, vertical, col_at_end, row_at_end);

    wa_axis #(.SIZE(COLS)) u_col (
        .clk    (clk),
        .rst    (rst),
        .load   (col_load),
        .ld_lo  (col_lo),
        .ld_hi  (col_hi),
        .step   (steps.col),
        .cur    (cur_col),
        .at_end (col_at_end)
    );

    wa_axis #(.SIZE(ROWS)) u_row (
        .clk    (clk),
        .rst    (rst),
        .load   (row_load),
        .ld_lo  (row_lo),
        .ld_hi  (row_hi),
        .step   (steps.row),
        .cur    (cur_row),
        .at_end (row_at_end)
    );

    wa_dirty u_dirty (
        .clk  (clk),
        .rst  (rst),
        .set  (data_valid),
        .clr  (redraw_clr),
        .flag (redraw)
    );

    // Write leaves in the strobe cycle, addressed by the pre-advance pointers
    assign wr_en   = data_valid;
    assign wr_data = data_in;
    assign wr_addr = AW'(cur_row) * AW'(COLS) + AW'(cur_col);
endmodule

// File: rtl/wa_frame_addr_chk.sv
module wa_frame_addr_chk #(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    localparam int CW  = $clog2(COLS),
    localparam int RW  = $clog2(ROWS)
) (
    input logic          clk,
    input logic          rst,
    input logic          data_valid,
    input logic          vertical,
    input logic          col_load,
    input logic          row_load,
    input logic          redraw_clr,
    input logic [CW-1:0] cur_col,
    input logic [RW-1:0] cur_row,
    input logic          col_at_end,
    input logic          row_at_end,
    input logic          redraw,
    input logic          wr_en
);
    // R3: horizontal step inside the window moves only the column
    a_r3_col_step: assert property (@(posedge clk) disable iff (rst)
        (data_valid && !vertical && !col_at_end && !col_load && !row_load)
        |=> (cur_col == CW'($past(cur_col) + 1'b1)) && (cur_row == $past(cur_row)));

    // R5: vertical step inside the window moves only the row
    a_r5_row_step: assert property (@(posedge clk) disable iff (rst)
        (data_valid && vertical && !row_at_end && !col_load && !row_load)
        |=> (cur_row == RW'($past(cur_row) + 1'b1)) && (cur_col == $past(cur_col)));

    // R10: no strobe and no load keeps both pointers
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!data_valid && !col_load && !row_load)
        |=> $stable(cur_col) && $stable(cur_row));

    // R10: no write enable without a data strobe
    a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
        !data_valid |-> !wr_en);

    // R9: a write always leaves the flag set
    a_r9_redraw_set: assert property (@(posedge clk) disable iff (rst)
        data_valid |=> redraw);

    // R9: only a clear drops the flag
    a_r9_redraw_keep: assert property (@(posedge clk) disable iff (rst)
        (redraw && !redraw_clr) |=> redraw);

    // R7: row pointer never leaves the frame
    a_r7_row_range: assert property (@(posedge clk) disable iff (rst)
        (32'(cur_row) < ROWS));
endmodule

bind wa_frame_addr wa_frame_addr_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .data_valid (data_valid),
    .vertical   (vertical),
    .col_load   (col_load),
    .row_load   (row_load),
    .redraw_clr (redraw_clr),
    .cur_col    (cur_col),
    .cur_row    (cur_row),
    .col_at_end (col_at_end),
    .row_at_end (row_at_end),
    .redraw     (redraw),
    .wr_en      (wr_en)
);

// File: tb/tb_wa_frame_addr.sv
module tb_wa_frame_addr;
    localparam int COLS = 8;
    localparam int ROWS = 10;
    localparam int CW = $clog2(COLS);
    localparam int RW = $clog2(ROWS);
    localparam int AW = $clog2(COLS * ROWS);
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] col_lo = '0, col_hi = '0;
    logic          col_load = 1'b0;
    logic [RW-1:0] row_lo = '0, row_hi = '0;
    logic          row_load = 1'b0;
    logic          vertical = 1'b0;
    logic          data_valid = 1'b0;
    logic [DW-1:0] data_in = '0;
    logic          redraw_clr = 1'b0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [CW-1:0] cur_col;
    logic [RW-1:0] cur_row;
    logic          redraw;

    int vec = 0;
    int bad = 0;
    int m_col, m_row, m_cs, m_ce, m_rs, m_re;

    always #2 clk = ~clk;

    wa_frame_addr #(.COLS(COLS), .ROWS(ROWS), .DW(DW)) dut (
        .clk(clk), .rst(rst),
        .col_lo(col_lo), .col_hi(col_hi), .col_load(col_load),
        .row_lo(row_lo), .row_hi(row_hi), .row_load(row_load),
        .vertical(vertical), .data_valid(data_valid), .data_in(data_in),
        .redraw_clr(redraw_clr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cur_col(cur_col), .cur_row(cur_row), .redraw(redraw)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Pointer advance taken from the requirement text
    task automatic model_step(input bit v);
        if (!v) begin
            if (m_col >= m_ce) begin
                m_col = m_cs;
                if (m_row >= m_re) m_row = m_rs; else m_row++;
            end else m_col++;
        end else begin
            if (m_row >= m_re) begin
                m_row = m_rs;
                if (m_col >= m_ce) m_col = m_cs; else m_col++;
            end else m_row++;
        end
    endtask

    task automatic do_load(input int cs, input int ce, input int rs, input int re);
        @(negedge clk);
        data_valid = 1'b0;
        col_lo = CW'(cs); col_hi = CW'(ce); col_load = 1'b1;
        row_lo = RW'(rs); row_hi = RW'(re); row_load = 1'b1;
        @(negedge clk);
        col_load = 1'b0; row_load = 1'b0;
        m_cs = cs % COLS; m_ce = ce % COLS; m_col = m_cs;
        m_rs = rs % ROWS; m_re = re % ROWS; m_row = m_rs;
        #1;
        chk("R6 col load", int'(cur_col), m_col);
        chk("R7 row load", int'(cur_row), m_row);
    endtask

    task automatic do_write(input bit v, input int d, input string tag);
        @(negedge clk);
        vertical = v; data_valid = 1'b1; data_in = DW'(d);
        #1;
        chk({tag, " R2 wr_en"}, int'(wr_en), 1);
        chk({tag, " R2 addr"}, int'(wr_addr), m_row * COLS + m_col);
        chk({tag, " R2 data"}, int'(wr_data), d & 8'hFF);
        model_step(v);
    endtask

    task automatic idle();
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        bad++;
        $display("FAIL R10 watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset col", int'(cur_col), 0);
        chk("R1 reset row", int'(cur_row), 0);
        chk("R1 reset redraw", int'(redraw), 0);
        chk("R2 idle wr_en", int'(wr_en), 0);
        rst = 1'b0;
        m_col = 0; m_row = 0; m_cs = 0; m_ce = COLS - 1; m_rs = 0; m_re = ROWS - 1;

        // R1: full window walks the whole frame and returns to 0
        for (int i = 0; i < COLS * ROWS + 3; i++)
            do_write(1'b0, i, "R1 R3 R4");
        idle();
        #1;
        chk("R9 redraw after writes", int'(redraw), 1);

        // R9: clear, then clear together with a write
        @(negedge clk); redraw_clr = 1'b1;
        @(negedge clk); redraw_clr = 1'b0;
        #1;
        chk("R9 redraw cleared", int'(redraw), 0);
        @(negedge clk); redraw_clr = 1'b1;
        vertical = 1'b0; data_valid = 1'b1; data_in = 8'h5A;
        model_step(1'b0);
        @(negedge clk); redraw_clr = 1'b0; data_valid = 1'b0;
        #1;
        chk("R9 write beats clear", int'(redraw), 1);

        // R10: idle cycles keep the pointers
        repeat (3) @(negedge clk);
        #1;
        chk("R10 hold col", int'(cur_col), m_col);
        chk("R10 hold row", int'(cur_row), m_row);
        chk("R10 no write", int'(wr_en), 0);

        // R8: end below start on both axes
        do_load(5, 2, 3, 1);
        do_write(1'b0, 8'h11, "R8 h1");
        do_write(1'b0, 8'h12, "R8 h2");
        do_write(1'b1, 8'h13, "R8 v1");
        idle();
        #1;
        chk("R8 col stays at start", int'(cur_col), 5);
        chk("R8 row stays at start", int'(cur_row), 3);

        // Sweep A: every column window, a few row windows, both orders
        for (int v = 0; v < 2; v++)
            for (int cs = 0; cs < COLS; cs++)
                for (int ce = 0; ce < COLS; ce++)
                    for (int k = 0; k < 3; k++) begin
                        int rs, re;
                        rs = (k == 0) ? 0 : (k == 1) ? 7 : 13;
                        re = (k == 0) ? 9 : (k == 1) ? 2 : 14;
                        do_load(cs, ce, rs, re);
                        for (int n = 0; n < 20; n++)
                            do_write(v[0], cs * 16 + n, v ? "R5 R8 sweepA" : "R3 R4 R8 sweepA");
                        idle();
                    end

        // Sweep B: every row code pair (with folding), a few column windows
        for (int v = 0; v < 2; v++)
            for (int rs = 0; rs < 16; rs++)
                for (int re = 0; re < 16; re++)
                    for (int k = 0; k < 2; k++) begin
                        do_load(k ? 5 : 0, k ? 1 : 7, rs, re);
                        for (int n = 0; n < 20; n++)
                            do_write(v[0], rs * 16 + n, v ? "R5 R7 sweepB" : "R3 R4 R7 sweepB");
                        idle();
                    end

        idle();
        #1;
        chk("R10 final no write", int'(wr_en), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule